// File: doc/BRIEF.md
# Display Power-State Sequencer

This block moves a display module between three power states: deep standby, sleep and normal. A controller asks for a target state. The block then walks a fixed, ordered script of register writes through an attached serial command transmitter. If the target is two steps away, the block runs the two single-step scripts back to back and passes through sleep on the way.

The block also drives the module's active-low reset. It releases the reset right after its own reset ends, then holds off all traffic for a programmable settling time. The default is 90 ms at 50 MHz, which is longer than the nominal 50 ms because that figure proved marginal. Two separate strobes send the blank and unblank commands without changing the power state. The block reports the current state and a busy flag. The panel tuning table sent on the way up to normal is held as a short internal list of entries, each with an address, a length and data.

Top module: `panel_power_seq`

## Requirements
- R1: While `rst_n` is low, `panel_rst_n` is 0, `busy` is 1, `cmd_valid` is 0 and `cur_state` is 0. State encoding: 0 = deep standby, 1 = sleep, 2 = normal.
- R2: `panel_rst_n` rises on the first clock after reset. `busy` then stays high for exactly `WAIT_CYC` more clocks. No command is issued in that window, and requests made during it are dropped.
- R3: A request for the current state, or for the unused code 3, issues nothing and changes nothing.
- R4: Deep standby to sleep issues three no-payload commands with address 0x00, then writes 0x17 to 0xB0.
- R5: Sleep to normal issues, in this order: 0xBC←0x80, 0x3B←0x00, 0xB0←0x16, 0xB8←16-bit 0xFFF9, then no-payload 0x11. It then sends the tuning entries 0xBA←0x01, 0xBB←0x00, 0x3A←0x60 and 0xBF←0x10.
- R6: Normal to sleep issues no-payload 0x28, then 0xB8←16-bit 0x8002, then no-payload 0x10.
- R7: Sleep to deep standby writes 0x00 to 0xB0.
- R8: Deep standby to normal is the R4 script followed by the R5 script. Normal to deep standby is the R6 script followed by the R7 script.
- R9: Command handshake. `cmd_len` is 0 for no payload, 1 for one byte in `cmd_data[7:0]`, and 2 for two bytes in `cmd_data[15:0]` with the high byte sent first. Unused data bits are 0. `cmd_valid` stays high, with address, length and data stable, until a cycle in which `cmd_done` is high. The next entry follows in the next cycle.
- R10: A `disp_on` strobe issues no-payload 0x29, and a `disp_off` strobe issues no-payload 0x28. Neither changes `cur_state`. If both strobes arrive together, `disp_on` wins. A valid state change in the same cycle wins over both.
- R11: While `busy` is high, all requests and display strobes are ignored.
- R12: `cur_state` changes only once the whole chained script has completed. Until then it holds the starting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Strobe: move to `req_state` |
| req_state | input | 2 | Requested power state |
| disp_on | input | 1 | Strobe: unblank display |
| disp_off | input | 1 | Strobe: blank display |
| cmd_done | input | 1 | Transmitter has finished the current command |
| panel_rst_n | output | 1 | Active-low reset to the display module |
| cmd_valid | output | 1 | A command is presented |
| cmd_addr | output | 8 | Command / register address |
| cmd_len | output | 2 | Payload length in bytes (0, 1, 2) |
| cmd_data | output | 16 | Payload |
| cur_state | output | 2 | Current power state |
| busy | output | 1 | Settling wait or a script is in progress |

## Verification
The hardest situation to reach is the middle of a chained transition. In that window `cur_state` must still show the starting state, even though the first half of the script is already done, and any new requests must be dropped. The bench sweeps all nine start/target pairs and samples `cur_state` on every cycle while `busy` is high. It also fires a competing state request and both display strobes in the middle of the longest script, then compares the captured command log entry by entry. A model transmitter varies its done latency from zero to two cycles, so the hold-until-done handshake is exercised with back-to-back and stretched commands.

// File: rtl/panel_power_seq.sv
module panel_power_seq #(
  parameter int WAIT_CYC = 4500000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_state,
  input  logic        disp_on,
  input  logic        disp_off,
  input  logic        cmd_done,
  output logic        panel_rst_n,
  output logic        cmd_valid,
  output logic [7:0]  cmd_addr,
  output logic [1:0]  cmd_len,
  output logic [15:0] cmd_data,
  output logic [1:0]  cur_state,
  output logic        busy
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [4:0] UP_FIRST   = 5'd0;
  localparam logic [4:0] UP_LAST    = 5'd3;
  localparam logic [4:0] WAKE_FIRST = 5'd4;
  localparam logic [4:0] WAKE_LAST  = 5'd12;
  localparam logic [4:0] DOWN_FIRST = 5'd13;
  localparam logic [4:0] DOWN_LAST  = 5'd15;
  localparam logic [4:0] OFF_STEP   = 5'd16;
  localparam logic [4:0] UNBLANK    = 5'd17;
  localparam logic [4:0] BLANK      = 5'd18;

  typedef enum logic [1:0] {PH_WAIT, PH_IDLE, PH_RUN} phase_t;

  phase_t        ph;
  logic [4:0]    idx, stop;
  logic [1:0]    goal, cur;
  logic [CW-1:0] cnt;
  logic          rel;
  logic [25:0]   ent;

  logic          go;
  logic [4:0]    go_first, go_last;
  logic [1:0]    go_goal;

  function automatic logic [25:0] step(input logic [4:0] i);
    case (i)
      5'd0, 5'd1, 5'd2: step = {8'h00, 2'd0, 16'h0000};
      5'd3:  step = {8'hB0, 2'd1, 16'h0017};
      5'd4:  step = {8'hBC, 2'd1, 16'h0080};
      5'd5:  step = {8'h3B, 2'd1, 16'h0000};
      5'd6:  step = {8'hB0, 2'd1, 16'h0016};
      5'd7:  step = {8'hB8, 2'd2, 16'hFFF9};
      5'd8:  step = {8'h11, 2'd0, 16'h0000};
      5'd9:  step = {8'hBA, 2'd1, 16'h0001};
      5'd10: step = {8'hBB, 2'd1, 16'h0000};
      5'd11: step = {8'h3A, 2'd1, 16'h0060};
      5'd12: step = {8'hBF, 2'd1, 16'h0010};
      5'd13: step = {8'h28, 2'd0, 16'h0000};
      5'd14: step = {8'hB8, 2'd2, 16'h8002};
      5'd15: step = {8'h10, 2'd0, 16'h0000};
      5'd16: step = {8'hB0, 2'd1, 16'h0000};
      5'd17: step = {8'h29, 2'd0, 16'h0000};
      5'd18: step = {8'h28, 2'd0, 16'h0000};
      default: step = '0;
    endcase
  endfunction

  assign ent         = step(idx);
  assign cmd_addr    = ent[25:18];
  assign cmd_len     = ent[17:16];
  assign cmd_data    = ent[15:0];
  assign cmd_valid   = (ph == PH_RUN);
  assign busy        = (ph != PH_IDLE);
  assign cur_state   = cur;
  assign panel_rst_n = rel;

  always_comb begin
    go       = 1'b0;
    go_first = '0;
    go_last  = '0;
    go_goal  = cur;
    if (req_valid && req_state != 2'd3 && req_state != cur) begin
      go      = 1'b1;
      go_goal = req_state;
      case ({cur, req_state})
        4'b0001: begin go_first = UP_FIRST;   go_last = UP_LAST;   end
        4'b0010: begin go_first = UP_FIRST;   go_last = WAKE_LAST; end
        4'b0110: begin go_first = WAKE_FIRST; go_last = WAKE_LAST; end
        4'b0100: begin go_first = OFF_STEP;   go_last = OFF_STEP;  end
        4'b1001: begin go_first = DOWN_FIRST; go_last = DOWN_LAST; end
        4'b1000: begin go_first = DOWN_FIRST; go_last = OFF_STEP;  end
        default: go = 1'b0;
      endcase
    end else if (disp_on) begin
      go       = 1'b1;
      go_first = UNBLANK;
      go_last  = UNBLANK;
    end else if (disp_off) begin
      go       = 1'b1;
      go_first = BLANK;
      go_last  = BLANK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_WAIT;
      rel  <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      stop <= '0;
      goal <= 2'd0;
      cur  <= 2'd0;
    end else begin
      case (ph)
        PH_WAIT: begin
          rel <= 1'b1;
          if (rel) begin
            if (cnt == CW'(WAIT_CYC - 1)) ph <= PH_IDLE;
            else cnt <= cnt + 1'b1;
          end
        end
        PH_IDLE: if (go) begin
          idx  <= go_first;
          stop <= go_last;
          goal <= go_goal;
          ph   <= PH_RUN;
        end
        PH_RUN: if (cmd_done) begin
          if (idx == stop) begin
            ph  <= PH_IDLE;
            cur <= goal;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_power_seq_chk.sv
module panel_power_seq_chk #(
  parameter int WAIT_CYC = 4500000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_state,
  input logic        disp_on,
  input logic        disp_off,
  input logic        cmd_done,
  input logic        panel_rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_addr,
  input logic [1:0]  cmd_len,
  input logic [15:0] cmd_data,
  input logic [1:0]  cur_state,
  input logic        busy
);
  logic [31:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rel <= '0;
    else if (panel_rst_n && since_rel < 32'(WAIT_CYC)) since_rel <= since_rel + 1'b1;
  end

  assert_no_early_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (panel_rst_n && since_rel >= 32'(WAIT_CYC)));

  assert_hold_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_data)));

  assert_len_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != 2'd3));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_state_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(cmd_valid && cmd_done)) |=> $stable(cur_state));

  assert_state_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state != 2'd3);
endmodule

bind panel_power_seq panel_power_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (.*);

// File: tb/panel_power_seq_tb.sv
module panel_power_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, disp_on = 0, disp_off = 0, cmd_done = 0;
  logic [1:0] req_state = 0;
  logic panel_rst_n, cmd_valid, busy;
  logic [7:0] cmd_addr;
  logic [1:0] cmd_len, cur_state;
  logic [15:0] cmd_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [25:0] lg [0:255];
  int ln = 0;
  logic [25:0] ex [0:31];
  int en = 0;

  panel_power_seq #(.WAIT_CYC(WAIT)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // model transmitter: latency 0..2 cycles, log each command
  initial begin
    forever begin
      @(negedge clk);
      cmd_done = 0;
      if (rst_n && cmd_valid) begin
        int lat;
        lat = ln % 3;
        if (ln < 256) lg[ln] = {cmd_addr, cmd_len, cmd_data};
        ln++;
        if (lat > 0) repeat (lat) @(negedge clk);
        cmd_done = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d);
    ex[en] = {a, l, d};
    en++;
  endtask

  task automatic exp_up();   // R4
    push(8'h00, 0, 0); push(8'h00, 0, 0); push(8'h00, 0, 0); push(8'hB0, 1, 16'h17);
  endtask
  task automatic exp_wake(); // R5
    push(8'hBC, 1, 16'h80); push(8'h3B, 1, 16'h00); push(8'hB0, 1, 16'h16);
    push(8'hB8, 2, 16'hFFF9); push(8'h11, 0, 0);
    push(8'hBA, 1, 16'h01); push(8'hBB, 1, 16'h00); push(8'h3A, 1, 16'h60); push(8'hBF, 1, 16'h10);
  endtask
  task automatic exp_down(); // R6
    push(8'h28, 0, 0); push(8'hB8, 2, 16'h8002); push(8'h10, 0, 0);
  endtask
  task automatic exp_off();  // R7
    push(8'hB0, 1, 16'h00);
  endtask

  task automatic wait_idle(input logic [1:0] from, input string tag);
    bit held = 1;
    while (busy) begin
      if (cur_state !== from) held = 0;
      @(negedge clk);
    end
    chk(held, {tag, " R12 state held while busy"}, {31'd0, held}, 1);
  endtask

  task automatic cmp_log(input int base, input string tag);
    chk(ln - base == en, {tag, " command count"}, ln - base, en);
    for (int i = 0; i < en; i++)
      chk(lg[base + i] === ex[i], {tag, " command entry"}, {6'd0, lg[base + i]}, {6'd0, ex[i]});
  endtask

  task automatic do_req(input logic [1:0] from, input logic [1:0] to, input bit interfere, input string tag);
    int base;
    logic [1:0] want;
    en = 0;
    base = ln;
    want = (to == 2'd3 || to == from) ? from : to;
    case ({from, to})
      4'b0001: exp_up();
      4'b0010: begin exp_up(); exp_wake(); end
      4'b0110: exp_wake();
      4'b0100: exp_off();
      4'b1001: exp_down();
      4'b1000: begin exp_down(); exp_off(); end
      default: ;
    endcase
    @(negedge clk); req_valid = 1; req_state = to;
    @(negedge clk); req_valid = 0;
    chk(busy === (want != from), {tag, " busy after request"}, {31'd0, busy}, {31'd0, want != from});
    if (interfere) begin  // R11
      @(negedge clk); req_valid = 1; req_state = 2'd0; disp_on = 1; disp_off = 1;
      @(negedge clk); req_valid = 0; disp_on = 0; disp_off = 0;
    end
    wait_idle(from, tag);
    repeat (4) @(negedge clk);
    cmp_log(base, tag);
    chk(cur_state === want, {tag, " final state"}, cur_state, want);
  endtask

  task automatic do_disp(input bit on, input bit off, input bit with_req, input logic [1:0] rq, input string tag);
    int base;
    logic [1:0] st;
    st = cur_state;
    base = ln;
    en = 0;
    @(negedge clk); disp_on = on; disp_off = off; req_valid = with_req; req_state = rq;
    @(negedge clk); disp_on = 0; disp_off = 0; req_valid = 0;
    wait_idle(st, tag);
    repeat (3) @(negedge clk);
    if (with_req) begin
      if (st == 2'd0 && rq == 2'd1) exp_up();
    end else if (on) push(8'h29, 0, 0);
    else push(8'h28, 0, 0);
    cmp_log(base, tag);
    chk(cur_state === (with_req ? rq : st), {tag, " state after display strobe"}, cur_state, with_req ? rq : st);
  endtask

  initial begin
    int n;
    #1;
    // R1 reset values
    chk(panel_rst_n === 0, "R1 panel reset low", {31'd0, panel_rst_n}, 0);
    chk(busy === 1, "R1 busy in reset", {31'd0, busy}, 1);
    chk(cmd_valid === 0, "R1 no command in reset", {31'd0, cmd_valid}, 0);
    chk(cur_state === 0, "R1 state standby", cur_state, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(panel_rst_n === 1, "R2 panel reset released", {31'd0, panel_rst_n}, 1);
    n = 0;
    while (busy) begin
      if (n == 5) begin req_valid = 1; req_state = 2'd2; disp_on = 1; end  // R2 ignored during wait
      if (n == 6) begin req_valid = 0; disp_on = 0; end
      @(negedge clk);
      n++;
    end
    chk(n == WAIT, "R2 settle length", n, WAIT);
    repeat (4) @(negedge clk);
    chk(ln == 0, "R2 no command during settle", ln, 0);
    chk(cur_state === 0, "R2 request during settle dropped", cur_state, 0);

    do_req(0, 0, 0, "R3 same state standby");
    do_req(0, 3, 0, "R3 code 3 ignored");
    do_req(0, 1, 0, "R4 standby to sleep");
    do_req(1, 1, 0, "R3 same state sleep");
    do_req(1, 2, 1, "R5 R11 sleep to normal");
    do_req(2, 2, 0, "R3 same state normal");
    do_disp(1, 0, 0, 0, "R10 unblank");
    do_disp(0, 1, 0, 0, "R10 blank");
    do_disp(1, 1, 0, 0, "R10 both strobes");
    do_req(2, 1, 0, "R6 normal to sleep");
    do_req(1, 0, 0, "R7 sleep to standby");
    do_req(0, 2, 1, "R8 R11 standby to normal");
    do_req(2, 0, 0, "R8 normal to standby");
    do_disp(1, 0, 1, 2'd1, "R10 request beats strobe");
    do_req(1, 0, 0, "R7 back to standby");
    do_disp(0, 1, 0, 0, "R10 blank in standby");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule